// File: doc/BRIEF.md
# Phase-continuous FSK transmit modulator

The block turns bytes into a two-tone audio-band sample stream for a current-loop field modem. Each byte arrives over a valid/ready handshake. The block wraps it in an asynchronous character: a start bit, eight data bits sent least significant first, an odd parity bit and a stop bit. It shifts the bits out at 1200 baud. Each bit selects one of two phase increments for a phase accumulator. The top eight accumulator bits address a folded quarter-wave sine table, which produces a signed sample once per sample period. A tone change only swaps the increment, so the waveform has no phase step at bit boundaries.

The stream is enabled by an active-low request-to-send input. While it is low and no character is pending, the block sends a steady mark tone. While it is high, every sample is zero and the accumulator rests at zero. A byte offered during the stop bit of the current character follows it directly, so a burst of bytes leaves with no idle bits between characters. Conversion to analog, filtering and line drive happen downstream.

Top module: `fsk_tx_mod`

## Requirements
- R1: A 1 (mark) bit uses phase increment round(MARK_HZ·2^ACC_W/SAMPLE_HZ) and a 0 (space) bit uses round(SPACE_HZ·2^ACC_W/SAMPLE_HZ), with defaults of 1200 Hz and 2200 Hz. Each strobed sample is the sine of the accumulator value before that sample's increment is added.
- R2: The accumulator is never reloaded at a bit or character boundary while enabled. Only the increment changes, so the phase stays continuous across tone changes.
- R3: `samp_stb` is a one-cycle pulse every CLK_HZ/SAMPLE_HZ clocks. Each bit lasts SAMPLE_HZ/BAUD samples, which is 1200 baud.
- R4: A character is sent as the bit sequence start (0), data bit 0 through data bit 7, parity, stop (1). The parity bit makes the number of ones among the data and parity bits odd.
- R5: A byte accepted during bit period k (bit periods are counted in samples from the start of enable) begins its start bit at period k+1. A byte accepted during the stop bit therefore follows the current character with no gap.
- R6: While enabled with no character in flight or pending, every bit period carries mark tone.
- R7: While `rts_n` is high, strobed samples are 0, `in_ready` is 0, any character in flight or pending is dropped and `busy` is 0. After `rts_n` falls, the first sample is taken at phase 0 and bit period 0 starts there.
- R8: When enabled, `in_ready` is high when no character is in flight, or during the stop bit of the character in flight, provided no byte is already pending. It is low in the cycle after an accepted byte.
- R9: `busy` is high from the cycle after a byte is accepted until the stop bit of the last character ends.
- R10: The sample is AMP·sin(2π(p+0.5)/256), where p is the top eight accumulator bits and AMP = 2^(OUT_W-1)−1. The value lies within ±6 codes of this, and the table is folded across the four quadrants.
- R11: After reset, `samp`, `samp_stb`, `busy` and `in_ready` are 0 while `rts_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rts_n | input | 1 | Active-low transmit enable |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Byte can be taken this cycle |
| samp | output | OUT_W | Signed sine sample |
| samp_stb | output | 1 | New sample on `samp` |
| busy | output | 1 | Character in flight or pending |

## Verification
The bench keeps its own phase accumulator and bit schedule, and checks every sample against a real-valued sine. It drives four kinds of pattern, each with a different purpose:
- Bytes of all zeros, all ones and alternating bits, which separate a wrong tone assignment from a wrong bit order or parity.
- A byte queued during the previous stop bit, which exposes any gap bit or late start between characters.
- Random bytes with random idle spacing, which mix mark runs and tone changes at arbitrary phases, so that a phase reload at a boundary shows.
- A disable in the middle of a character followed by re-enable, which checks the zero output, the dropped character and the restart at phase zero.

// File: rtl/fsk_tx_mod.sv
module fsk_tx_mod #(
  parameter int CLK_HZ    = 9_600_000,
  parameter int SAMPLE_HZ = 38_400,
  parameter int BAUD      = 1200,
  parameter int MARK_HZ   = 1200,
  parameter int SPACE_HZ  = 2200,
  parameter int ACC_W     = 16,
  parameter int OUT_W     = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rts_n,
  input  logic                    in_valid,
  input  logic [7:0]              in_data,
  output logic                    in_ready,
  output logic signed [OUT_W-1:0] samp,
  output logic                    samp_stb,
  output logic                    busy
);
  localparam int SDIV   = CLK_HZ / SAMPLE_HZ;
  localparam int SPB    = SAMPLE_HZ / BAUD;
  localparam int SDIV_W = $clog2(SDIV);
  localparam int SPB_W  = $clog2(SPB);
  localparam longint AMP = (64'd1 << (OUT_W - 1)) - 1;
  localparam logic [ACC_W-1:0] INC_MARK =
    ACC_W'(((64'(MARK_HZ) << ACC_W) + SAMPLE_HZ / 2) / SAMPLE_HZ);
  localparam logic [ACC_W-1:0] INC_SPACE =
    ACC_W'(((64'(SPACE_HZ) << ACC_W) + SAMPLE_HZ / 2) / SAMPLE_HZ);

  function automatic logic [OUT_W-2:0] qval(input int i);
    longint t, p, num, den;
    t   = 2 * i + 1;
    p   = t * (256 - t);
    num = AMP * 16 * p;
    den = 5 * 65536 - 4 * p;
    return (OUT_W-1)'((num + den / 2) / den);
  endfunction

  logic [OUT_W-2:0] qtab [64];
  for (genvar g = 0; g < 64; g++) begin : g_tab
    assign qtab[g] = qval(g);
  end

  logic              en;
  logic [SDIV_W-1:0] sdiv;
  logic [SPB_W-1:0]  scnt;
  logic [ACC_W-1:0]  acc;
  logic [10:0]       sh;
  logic [3:0]        bitpos;
  logic              act, nxt_v;
  logic [7:0]        nxt;
  logic              tick, bnd, tx_bit;

  assign en     = ~rts_n;
  assign tick   = sdiv == SDIV_W'(SDIV - 1);
  assign bnd    = tick && scnt == SPB_W'(SPB - 1);
  assign tx_bit = act ? sh[0] : 1'b1;
  assign in_ready = en && !nxt_v && (!act || bitpos == 4'd10);
  assign busy   = act || nxt_v;

  logic [1:0]              quad;
  logic [5:0]              idx;
  logic signed [OUT_W-1:0] magx, sine;
  assign quad = acc[ACC_W-1 -: 2];
  assign idx  = quad[0] ? ~acc[ACC_W-3 -: 6] : acc[ACC_W-3 -: 6];
  assign magx = {1'b0, qtab[idx]};
  assign sine = quad[1] ? -magx : magx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdiv <= '0; samp_stb <= 1'b0; samp <= '0; acc <= '0; scnt <= '0;
      sh <= '1; bitpos <= '0; act <= 1'b0; nxt_v <= 1'b0; nxt <= '0;
    end else begin
      sdiv     <= tick ? '0 : sdiv + 1'b1;
      samp_stb <= tick;
      if (!en) begin
        acc <= '0; scnt <= '0; act <= 1'b0; nxt_v <= 1'b0; bitpos <= '0;
        if (tick) samp <= '0;
      end else begin
        if (in_valid && in_ready) begin
          nxt   <= in_data;
          nxt_v <= 1'b1;
        end
        if (tick) begin
          samp <= sine;
          acc  <= acc + (tx_bit ? INC_MARK : INC_SPACE);
          scnt <= bnd ? '0 : scnt + 1'b1;
        end
        if (bnd) begin
          if (act && bitpos != 4'd10) begin
            sh     <= {1'b1, sh[10:1]};
            bitpos <= bitpos + 1'b1;
          end else if (nxt_v) begin
            sh     <= {1'b1, ~^nxt, nxt, 1'b0};
            bitpos <= '0;
            act    <= 1'b1;
            nxt_v  <= 1'b0;
          end else begin
            act <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/fsk_tx_mod_chk.sv
module fsk_tx_mod_chk #(
  parameter int OUT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rts_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [OUT_W-1:0] samp,
  input logic             samp_stb,
  input logic             busy
);
  AST_READY_LOW_DISABLED: assert property (@(posedge clk) disable iff (!rst_n) rts_n |-> !in_ready); // R7
  AST_ZERO_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) (samp_stb && $past(rts_n)) |-> samp == '0); // R7
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) samp_stb |=> !samp_stb); // R3
  AST_SAMP_HELD: assert property (@(posedge clk) disable iff (!rst_n) !samp_stb |-> $stable(samp)); // R3
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready) |=> !in_ready); // R8
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready) |=> busy); // R9
endmodule

bind fsk_tx_mod fsk_tx_mod_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rts_n(rts_n), .in_valid(in_valid),
  .in_ready(in_ready), .samp(samp), .samp_stb(samp_stb), .busy(busy)
);

// File: tb/fsk_tx_mod_test.sv
module fsk_tx_mod_test;
  localparam int CLK_HZ = 960_000, SAMPLE_HZ = 38_400, BAUD = 1200;
  localparam int ACC_W = 16, OUT_W = 12;
  localparam int SDIV = CLK_HZ / SAMPLE_HZ;
  localparam int SPB  = SAMPLE_HZ / BAUD;
  localparam int INC_M = (1200 * 65536 + SAMPLE_HZ / 2) / SAMPLE_HZ;
  localparam int INC_S = (2200 * 65536 + SAMPLE_HZ / 2) / SAMPLE_HZ;
  localparam real AMP = 2047.0;

  logic clk = 0, rst_n = 0, rts_n = 1, in_valid = 0;
  logic [7:0] in_data = 0;
  logic in_ready, samp_stb, busy;
  logic signed [OUT_W-1:0] samp;

  fsk_tx_mod #(.CLK_HZ(CLK_HZ), .SAMPLE_HZ(SAMPLE_HZ), .BAUD(BAUD),
               .ACC_W(ACC_W), .OUT_W(OUT_W)) uut (
    .clk(clk), .rst_n(rst_n), .rts_n(rts_n), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .samp(samp),
    .samp_stb(samp_stb), .busy(busy));

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act_v, exp_v, $time);
    end
  endtask

  bit exp_bits [0:1023];
  int n_samp = 0, acc_ref = 0, acc_cnt = 0, last_start = 0, clk_since = 0;
  bit en_q = 0, prev_en = 0, seen_stb = 0;

  function automatic bit frame_bit(input logic [7:0] d, input int k);
    if (k == 0) return 1'b0;
    if (k <= 8) return d[k-1];
    if (k == 9) return ~^d;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    en_q = !rts_n;
    clk_since++;
    if (rst_n && in_valid && in_ready) begin
      last_start = n_samp / SPB + 1;
      for (int k = 0; k < 11; k++)
        exp_bits[(last_start + k) % 1024] = frame_bit(in_data, k);
      acc_cnt++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && samp_stb) begin
      if (seen_stb) chk(clk_since == SDIV, "R3 strobe spacing", clk_since, SDIV);
      seen_stb = 1; clk_since = 0;
      if (!en_q) begin
        chk(samp == 0, "R7 zero sample", samp, 0);
        n_samp = 0; acc_ref = 0; prev_en = 0;
        for (int i = 0; i < 1024; i++) exp_bits[i] = 1'b1;
      end else begin
        real e; int ei; bit b;
        e  = AMP * $sin(2.0 * 3.14159265358979 * ((acc_ref >> 8) + 0.5) / 256.0);
        ei = $rtoi(e >= 0.0 ? e + 0.5 : e - 0.5);
        chk((samp - ei) <= 6 && (ei - samp) <= 6, "R1/R2/R4/R5/R6/R10 sample", samp, ei);
        b = exp_bits[(n_samp / SPB) % 1024];
        acc_ref = (acc_ref + (b ? INC_M : INC_S)) & 16'hFFFF;
        n_samp++;
        prev_en = 1;
      end
    end
  end

  task automatic wait_stb();
    do @(negedge clk); while (!samp_stb);
  endtask

  task automatic send(input logic [7:0] d);
    int c;
    wait_stb();
    c = acc_cnt;
    in_valid = 1; in_data = d;
    while (acc_cnt == c) @(negedge clk);
    in_valid = 0;
  endtask

  task automatic wait_bits(input int nb);
    for (int i = 0; i < nb * SPB; i++) wait_stb();
  endtask

  initial begin
    int first;
    for (int i = 0; i < 1024; i++) exp_bits[i] = 1'b1;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    chk(samp == 0, "R11 samp", samp, 0);
    chk(samp_stb == 0, "R11 strobe", samp_stb, 0);
    chk(busy == 0, "R11 busy", busy, 0);
    chk(in_ready == 0, "R11 ready", in_ready, 0);
    rst_n = 1;
    repeat (6) wait_stb();
    rts_n = 0;
    @(negedge clk);
    chk(in_ready == 1, "R8 ready when idle", in_ready, 1);
    chk(busy == 0, "R9 idle busy", busy, 0);
    wait_bits(2);

    send(8'h00);
    @(negedge clk);
    chk(busy == 1, "R9 busy after accept", busy, 1);
    chk(in_ready == 0, "R8 ready after accept", in_ready, 0);
    first = last_start;
    wait_bits(3);
    chk(in_ready == 0, "R8 ready mid character", in_ready, 0);
    send(8'hFF);
    chk(last_start == first + 11, "R5 back to back start", last_start, first + 11);
    first = last_start;
    send(8'h55);
    chk(last_start == first + 11, "R5 back to back start", last_start, first + 11);
    wait_bits(13);
    chk(busy == 0, "R9 busy clears", busy, 0);
    chk(in_ready == 1, "R8 ready idle again", in_ready, 1);

    for (int r = 0; r < 6; r++) begin
      send(8'($urandom));
      for (int g = 0, ng = $urandom_range(0, 40); g < ng; g++) wait_stb();
    end
    wait_bits(13);
    chk(busy == 0, "R9 busy after random", busy, 0);

    send(8'hA7);
    wait_bits(3);
    rts_n = 1;
    @(negedge clk);
    chk(in_ready == 0, "R7 ready disabled", in_ready, 0);
    @(negedge clk);
    chk(busy == 0, "R7 character dropped", busy, 0);
    repeat (40) wait_stb();
    rts_n = 0;
    wait_bits(1);
    send(8'h3C);
    wait_bits(14);
    chk(busy == 0, "R9 final idle", busy, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190_000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule